// File: doc/BRIEF.md
# Multicycle Five-Step Integer Core

This block is a small, non-pipelined integer core for a 32-bit instruction set with 32 general registers. Every instruction passes through up to five steps, one clock each: fetch, decode with register read, execute or address formation, memory access or branch resolution, and write-back. Each step hands its result to the next through a named latch: instruction word, next PC, operand A, operand B, sign-extended immediate, ALU result, branch condition and load data. Stores, branches, jumps and rejected words finish after the memory step. All other instructions also take the write-back step.

The top level wraps the core together with two word-addressed arrays, one for instructions and one for data. The arrays are written on the clock and read combinationally. A load port fills either array while the core is held in reset. The core then runs from address 0. Register writes, data stores, the current step, the PC and an illegal-instruction pulse are visible at the ports, so a test can follow execution without reaching inside the block.

Top module: `mc_sys`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0, `step_o` is 0 (fetch), and `illegal_o`, `wb_en_o` and `st_en_o` are all low. A load with `load_en` high writes `load_data` to word `load_addr` of the instruction array when `load_sel`=0, or of the data array when `load_sel`=1.
- R2: The step encoding is fetch=0, decode=1, execute=2, memory=3, write-back=4. Fetch is followed by decode, decode by execute, and execute by memory. After memory the core goes to write-back for register-writing instructions and to fetch for all others. Write-back is followed by fetch.
- R3: `pc_o` changes only at the end of the memory step. Any instruction that is not a taken branch and not a jump sets it to PC+4.
- R4: The instruction fields are: opcode in bits [31:26], rs1 in [25:21], the second field in [20:16] (rs2 for register ops, destination for immediate ops and loads, data source for stores), the register-op destination in [15:11], the function code in [10:0], and the immediate in [15:0]. The immediate is sign-extended from bit 15.
- R5: Opcode 0x00 is a register op. Its function code selects rd = rs1 op rs2: 0x020 add, 0x022 subtract, 0x024 and, 0x025 or, 0x026 xor, 0x02A signed set-less-than (result 1 or 0).
- R6: These immediate ops write rd = rs1 op sext(imm): 0x08 add, 0x0C and, 0x0D or, 0x0E xor.
- R7: A load (0x23) and a store (0x2B) use byte address rs1+sext(imm). The array word is selected by address bits [7:2]. A load writes that data word to the destination. A store writes the source register, and in its memory step raises `st_en_o` with `st_addr_o` = address and `st_data_o` = data.
- R8: Branch 0x04 is taken when rs1 equals zero; branch 0x05 is taken when rs1 is non-zero. A taken branch goes to (PC+4)+sext(imm). Neither branch writes a register.
- R9: A jump (0x02) goes to (PC+4) plus the 26-bit offset in [25:0], sign-extended. It writes no register.
- R10: Register 0 always reads as zero. Writes aimed at it are dropped, and `wb_en_o` never reports index 0.
- R11: An opcode not listed above, or a register op with an unlisted function code, writes no register and stores nothing. PC advances by 4, and `illegal_o` is high for exactly one cycle, during that instruction's execute step.
- R12: In the write-back step of a register-writing instruction with a non-zero destination, `wb_en_o` is high and `wb_idx_o`/`wb_val_o` carry the destination and the value written. The value is the load data for loads and the ALU result otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Array load strobe |
| load_sel | input | 1 | Load target: 0 instruction array, 1 data array |
| load_addr | input | 6 | Word index for a load |
| load_data | input | 32 | Word to load |
| pc_o | output | 32 | Current program counter |
| step_o | output | 3 | Current step code |
| illegal_o | output | 1 | Rejected-instruction pulse |
| wb_en_o | output | 1 | Register write strobe |
| wb_idx_o | output | 5 | Register being written |
| wb_val_o | output | 32 | Value being written |
| st_en_o | output | 1 | Data store strobe |
| st_addr_o | output | 32 | Byte address of the memory step |
| st_data_o | output | 32 | Data being stored |

## Verification
The assertions check the step sequencing on every cycle. They also check that the PC holds outside the memory step, that register writes only appear in write-back and never target register 0, that stores only appear in the memory step, and that the illegal pulse lasts one cycle and falls in the execute step. Computed values can only be shown by the bench's programs: ALU and immediate results, sign extension, effective addresses, load and store data, and the taken or not-taken outcome of branches and jumps, including a backward loop. The same holds for confirming that skipped or rejected instructions leave no register write behind.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;

  typedef enum logic [2:0] {
    ST_IF  = 3'd0,
    ST_ID  = 3'd1,
    ST_EX  = 3'd2,
    ST_MEM = 3'd3,
    ST_WB  = 3'd4
  } step_e;

  typedef enum logic [2:0] {
    K_RALU, K_IALU, K_LOAD, K_STORE, K_BEQZ, K_BNEZ, K_JUMP, K_ILL
  } kind_e;

  typedef enum logic [2:0] {
    A_ADD, A_SUB, A_AND, A_OR, A_XOR, A_SLT
  } aop_e;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_JMP  = 6'h02;
  localparam logic [5:0] OPC_BEQZ = 6'h04;
  localparam logic [5:0] OPC_BNEZ = 6'h05;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_ANDI = 6'h0C;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_XORI = 6'h0E;
  localparam logic [5:0] OPC_LDW  = 6'h23;
  localparam logic [5:0] OPC_STW  = 6'h2B;

  localparam logic [10:0] FN_ADD = 11'h020;
  localparam logic [10:0] FN_SUB = 11'h022;
  localparam logic [10:0] FN_AND = 11'h024;
  localparam logic [10:0] FN_OR  = 11'h025;
  localparam logic [10:0] FN_XOR = 11'h026;
  localparam logic [10:0] FN_SLT = 11'h02A;

  function automatic logic [XLEN-1:0] alu_calc(aop_e op, logic [XLEN-1:0] x, logic [XLEN-1:0] y);
    logic [XLEN-1:0] r;
    case (op)
      A_ADD:   r = x + y;
      A_SUB:   r = x - y;
      A_AND:   r = x & y;
      A_OR:    r = x | y;
      A_XOR:   r = x ^ y;
      A_SLT:   r = {{(XLEN-1){1'b0}}, ($signed(x) < $signed(y))};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] sext16(logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sext26(logic [25:0] v);
    return {{(XLEN-26){v[25]}}, v};
  endfunction
endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import mc_pkg::*;
(
  input  logic [XLEN-1:0]   ir,
  output kind_e             kind,
  output aop_e              aop,
  output logic [RIDX_W-1:0] rs1,
  output logic [RIDX_W-1:0] rs2,
  output logic [RIDX_W-1:0] rd,
  output logic              wr
);
  logic [5:0]  opc;
  logic [10:0] fn;

  assign opc = ir[31:26];
  assign fn  = ir[10:0];
  assign rs1 = ir[25:21];
  assign rs2 = ir[20:16];

  always_comb begin
    kind = K_ILL;
    aop  = A_ADD;
    case (opc)
      OPC_REG: begin
        kind = K_RALU;
        case (fn)
          FN_ADD:  aop = A_ADD;
          FN_SUB:  aop = A_SUB;
          FN_AND:  aop = A_AND;
          FN_OR:   aop = A_OR;
          FN_XOR:  aop = A_XOR;
          FN_SLT:  aop = A_SLT;
          default: kind = K_ILL;
        endcase
      end
      OPC_ADDI: begin kind = K_IALU; aop = A_ADD; end
      OPC_ANDI: begin kind = K_IALU; aop = A_AND; end
      OPC_ORI:  begin kind = K_IALU; aop = A_OR;  end
      OPC_XORI: begin kind = K_IALU; aop = A_XOR; end
      OPC_LDW:  kind = K_LOAD;
      OPC_STW:  kind = K_STORE;
      OPC_BEQZ: kind = K_BEQZ;
      OPC_BNEZ: kind = K_BNEZ;
      OPC_JMP:  kind = K_JUMP;
      default:  kind = K_ILL;
    endcase
  end

  // destination field depends on format
  assign rd = (kind == K_RALU) ? ir[15:11] : ir[20:16];
  assign wr = (kind == K_RALU) || (kind == K_IALU) || (kind == K_LOAD);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] ra1,
  input  logic [IW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [IW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/mc_engine.sv
module mc_engine
  import mc_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   imem_rdata,
  input  logic [XLEN-1:0]   dmem_rdata,
  output logic [XLEN-1:0]   pc,
  output step_e             step,
  output logic              illegal,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_val,
  output logic              st_en,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   st_data
);
  step_e           step_q;
  logic [XLEN-1:0] pc_q, ir_q, npc_q, a_q, b_q, imm_q, aluo_q, lmd_q;
  logic            cond_q;

  kind_e             kind;
  aop_e              aop;
  logic [RIDX_W-1:0] rs1, rs2, rd;
  logic              wr;

  mc_decode u_dec (
    .ir(ir_q), .kind(kind), .aop(aop), .rs1(rs1), .rs2(rs2), .rd(rd), .wr(wr)
  );

  logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd;
  logic            rf_we;

  mc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra1(rs1), .ra2(rs2), .rd1(rf_rd1), .rd2(rf_rd2),
    .we(rf_we), .wa(rd), .wd(rf_wd)
  );

  // operand selection for the execute step
  logic [XLEN-1:0] alu_x, alu_y, alu_r;
  aop_e            alu_op;

  always_comb begin
    alu_x  = a_q;
    alu_y  = imm_q;
    alu_op = A_ADD;
    case (kind)
      K_RALU:         begin alu_y = b_q; alu_op = aop; end
      K_IALU:         alu_op = aop;
      K_BEQZ, K_BNEZ: alu_x = npc_q;
      K_JUMP:         begin alu_x = npc_q; alu_y = sext26(ir_q[25:0]); end
      default:        ;
    endcase
  end

  assign alu_r = alu_calc(alu_op, alu_x, alu_y);

  // named events
  logic ev_is_branch, ev_redirect, ev_goto_wb;
  assign ev_is_branch = (kind == K_BEQZ) || (kind == K_BNEZ);
  assign ev_redirect  = (ev_is_branch && cond_q) || (kind == K_JUMP);
  assign ev_goto_wb   = wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IF;
      pc_q   <= '0;
      ir_q   <= '0;
      npc_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      imm_q  <= '0;
      aluo_q <= '0;
      lmd_q  <= '0;
      cond_q <= 1'b0;
    end else begin
      case (step_q)
        ST_IF: begin
          ir_q   <= imem_rdata;
          npc_q  <= pc_q + 32'd4;
          step_q <= ST_ID;
        end
        ST_ID: begin
          a_q    <= rf_rd1;
          b_q    <= rf_rd2;
          imm_q  <= sext16(ir_q[15:0]);
          step_q <= ST_EX;
        end
        ST_EX: begin
          if (kind != K_ILL) aluo_q <= alu_r;
          cond_q <= (kind == K_BEQZ) ? (a_q == '0) : (a_q != '0);
          step_q <= ST_MEM;
        end
        ST_MEM: begin
          if (kind == K_LOAD) lmd_q <= dmem_rdata;
          pc_q   <= ev_redirect ? aluo_q : npc_q;
          step_q <= ev_goto_wb ? ST_WB : ST_IF;
        end
        default: step_q <= ST_IF;
      endcase
    end
  end

  assign rf_we = (step_q == ST_WB) && wr;
  assign rf_wd = (kind == K_LOAD) ? lmd_q : aluo_q;

  assign pc       = pc_q;
  assign step     = step_q;
  assign illegal  = (step_q == ST_EX) && (kind == K_ILL);
  assign wb_en    = rf_we && (rd != '0);
  assign wb_idx   = rd;
  assign wb_val   = rf_wd;
  assign st_en    = (step_q == ST_MEM) && (kind == K_STORE);
  assign mem_addr = aluo_q;
  assign st_data  = b_q;
endmodule

// File: rtl/mc_sys.sv
module mc_sys
  import mc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int LD_AW = $clog2((IMEM_WORDS > DMEM_WORDS) ? IMEM_WORDS : DMEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              load_sel,
  input  logic [LD_AW-1:0]  load_addr,
  input  logic [XLEN-1:0]   load_data,
  output logic [XLEN-1:0]   pc_o,
  output logic [2:0]        step_o,
  output logic              illegal_o,
  output logic              wb_en_o,
  output logic [RIDX_W-1:0] wb_idx_o,
  output logic [XLEN-1:0]   wb_val_o,
  output logic              st_en_o,
  output logic [XLEN-1:0]   st_addr_o,
  output logic [XLEN-1:0]   st_data_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem_rdata, dmem_rdata, pc_w, maddr_w, sdata_w;
  logic            st_w;
  step_e           step_w;

  mc_engine u_core (
    .clk(clk), .rst_n(rst_n),
    .imem_rdata(imem_rdata), .dmem_rdata(dmem_rdata),
    .pc(pc_w), .step(step_w), .illegal(illegal_o),
    .wb_en(wb_en_o), .wb_idx(wb_idx_o), .wb_val(wb_val_o),
    .st_en(st_w), .mem_addr(maddr_w), .st_data(sdata_w)
  );

  logic           d_we;
  logic [DAW-1:0] d_waddr;
  logic [XLEN-1:0] d_wdata;

  assign d_we    = (load_en && load_sel) || st_w;
  assign d_waddr = (load_en && load_sel) ? load_addr[DAW-1:0] : maddr_w[DAW+1:2];
  assign d_wdata = (load_en && load_sel) ? load_data : sdata_w;

  mc_mem #(.DEPTH(IMEM_WORDS), .W(XLEN)) u_imem (
    .clk(clk), .we(load_en && !load_sel), .waddr(load_addr[IAW-1:0]), .wdata(load_data),
    .raddr(pc_w[IAW+1:2]), .rdata(imem_rdata)
  );

  mc_mem #(.DEPTH(DMEM_WORDS), .W(XLEN)) u_dmem (
    .clk(clk), .we(d_we), .waddr(d_waddr), .wdata(d_wdata),
    .raddr(maddr_w[DAW+1:2]), .rdata(dmem_rdata)
  );

  logic unused_bits;
  assign unused_bits = ^{pc_w, maddr_w, load_addr};

  assign pc_o      = pc_w;
  assign step_o    = step_w;
  assign st_en_o   = st_w;
  assign st_addr_o = maddr_w;
  assign st_data_o = sdata_w;
endmodule

// File: rtl/mc_sys_chk.sv
module mc_sys_chk
  import mc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        step,
  input logic [XLEN-1:0]   pc,
  input logic              illegal,
  input logic              wb_en,
  input logic [RIDX_W-1:0] wb_idx,
  input logic              st_en
);
  assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step <= 3'd4);
  assert_if_to_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 3'd0) |=> (step == 3'd1));
  assert_id_to_ex_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 3'd1) |=> (step == 3'd2));
  assert_ex_to_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 3'd2) |=> (step == 3'd3));
  assert_mem_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 3'd3) |=> ((step == 3'd0) || (step == 3'd4)));
  assert_wb_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 3'd4) |=> (step == 3'd0));
  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step != 3'd3) |=> $stable(pc));
  assert_wb_slot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (step == 3'd4));
  assert_no_r0_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_idx != '0));
  assert_store_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> (step == 3'd3));
  assert_ill_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (step == 3'd2));
  assert_ill_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal);
endmodule

bind mc_sys mc_sys_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step(step_o), .pc(pc_o), .illegal(illegal_o),
  .wb_en(wb_en_o), .wb_idx(wb_idx_o), .st_en(st_en_o)
);

// File: tb/tb_mc_sys.sv
module tb_mc_sys;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic        load_sel = 1'b0;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] pc_o, wb_val_o, st_addr_o, st_data_o;
  logic [2:0]  step_o;
  logic        illegal_o, wb_en_o, st_en_o;
  logic [4:0]  wb_idx_o;

  mc_sys dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_sel(load_sel),
    .load_addr(load_addr), .load_data(load_data),
    .pc_o(pc_o), .step_o(step_o), .illegal_o(illegal_o),
    .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_val_o(wb_val_o),
    .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;

  logic [31:0] prog [64];
  logic [31:0] dpre [64];

  // event log filled from the ports
  int          wcnt [32];
  logic [31:0] wval [32];
  int          st_cnt, ill_cnt, ill_run, ill_max;
  logic [31:0] st_addr_l, st_data_l;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin wcnt[i] = 0; wval[i] = '0; end
      st_cnt = 0; ill_cnt = 0; ill_run = 0; ill_max = 0;
      st_addr_l = '0; st_data_l = '0;
    end else begin
      if (wb_en_o) begin wcnt[wb_idx_o]++; wval[wb_idx_o] = wb_val_o; end
      if (st_en_o) begin st_cnt++; st_addr_l = st_addr_o; st_data_l = st_data_o; end
      if (illegal_o) begin
        ill_cnt++; ill_run++;
        if (ill_run > ill_max) ill_max = ill_run;
      end else ill_run = 0;
    end
  end

  // encoders (bench's own restatement of the field layout)
  function automatic logic [31:0] ei(logic [5:0] op, int rs1, int rd, int imm);
    return {op, 5'(rs1), 5'(rd), 16'(imm)};
  endfunction
  function automatic logic [31:0] er(int rs1, int rs2, int rd, logic [10:0] fn);
    return {6'h00, 5'(rs1), 5'(rs2), 5'(rd), fn};
  endfunction
  function automatic logic [31:0] ej(int off);
    return {6'h02, 26'(off)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr_prog();
    for (int i = 0; i < 64; i++) begin prog[i] = ej(-4); dpre[i] = '0; end
  endtask

  task automatic boot();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) begin
      load_en = 1'b1; load_sel = 1'b0; load_addr = 6'(i); load_data = prog[i];
      @(negedge clk);
    end
    for (int i = 0; i < 64; i++) begin
      load_en = 1'b1; load_sel = 1'b1; load_addr = 6'(i); load_data = dpre[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 pc in reset", pc_o, 32'd0);
    chk("R1 step in reset", 32'(step_o), 32'd0);
    chk("R1 quiet outputs", {29'd0, illegal_o, wb_en_o, st_en_o}, 32'd0);
  endtask

  task automatic t_timing();
    int exp_step [14] = '{0,1,2,3,4,0,1,2,3,0,1,2,3,0};
    int exp_pc   [14] = '{0,0,0,0,4,4,4,4,4,8,8,8,8,8};
    clr_prog();
    prog[0] = ei(6'h08, 0, 1, 5);   // addi r1 = 5
    prog[1] = ei(6'h2B, 0, 1, 0);   // store r1 -> [0]
    boot();
    for (int k = 0; k < 14; k++) begin
      chk($sformatf("R2 step at cycle %0d", k), 32'(step_o), 32'(exp_step[k]));
      chk($sformatf("R3 pc at cycle %0d", k), pc_o, 32'(exp_pc[k]));
      if (k == 4) chk("R12 write-back strobe", {wb_en_o, 26'd0, wb_idx_o}, {1'b1, 26'd0, 5'd1});
      if (k == 8) chk("R7 store strobe in memory step", {31'd0, st_en_o}, 32'd1);
      @(negedge clk);
    end
    chk("R7 store data", st_data_l, 32'd5);
    chk("R7 store addr", st_addr_l, 32'd0);
    t_reset();
  endtask

  task automatic t_ralu();
    clr_prog();
    prog[0]  = ei(6'h08, 0, 1, 7);
    prog[1]  = ei(6'h08, 0, 2, -3);
    prog[2]  = er(1, 2, 3, 11'h020);
    prog[3]  = er(1, 2, 4, 11'h022);
    prog[4]  = er(1, 2, 5, 11'h024);
    prog[5]  = er(1, 2, 6, 11'h025);
    prog[6]  = er(1, 2, 7, 11'h026);
    prog[7]  = er(2, 1, 8, 11'h02A);
    prog[8]  = er(1, 2, 9, 11'h02A);
    boot();
    run(60);
    chk("R5 add", wval[3], 32'd7 + 32'hFFFF_FFFD);
    chk("R5 sub", wval[4], 32'd7 - 32'hFFFF_FFFD);
    chk("R5 and", wval[5], 32'd7 & 32'hFFFF_FFFD);
    chk("R5 or",  wval[6], 32'd7 | 32'hFFFF_FFFD);
    chk("R5 xor", wval[7], 32'd7 ^ 32'hFFFF_FFFD);
    chk("R5 slt true (signed)", wval[8], 32'd1);
    chk("R5 slt false", {wval[9][30:0], 1'b0} | 32'(wcnt[9] != 1), 32'd0);
    chk("R4 rd field [15:11]", 32'(wcnt[2]), 32'd1);
  endtask

  task automatic t_ialu();
    clr_prog();
    prog[0] = ei(6'h08, 0, 1, 16'h0F0F);
    prog[1] = ei(6'h0E, 1, 2, 16'hFFFF);
    prog[2] = ei(6'h0D, 0, 3, 16'h8000);
    prog[3] = ei(6'h0C, 2, 4, 16'h00F0);
    boot();
    run(30);
    chk("R6 addi", wval[1], 32'h0000_0F0F);
    chk("R6 xori sign-extended", wval[2], 32'hFFFF_F0F0);
    chk("R6 ori sign-extended (R4)", wval[3], 32'hFFFF_8000);
    chk("R6 andi", wval[4], 32'h0000_00F0);
  endtask

  task automatic t_mem();
    clr_prog();
    dpre[3] = 32'hCAFE_F00D;
    dpre[5] = 32'h1234_5678;
    prog[0] = ei(6'h08, 0, 1, 8);
    prog[1] = ei(6'h23, 1, 2, 4);
    prog[2] = ei(6'h2B, 1, 2, -4);
    prog[3] = ei(6'h23, 0, 3, 4);
    prog[4] = ei(6'h23, 0, 4, 20);
    boot();
    run(40);
    chk("R7 load base+disp", wval[2], 32'hCAFE_F00D);
    chk("R7 store negative disp addr", st_addr_l, 32'd4);
    chk("R7 store data", st_data_l, 32'hCAFE_F00D);
    chk("R7 load sees stored word", wval[3], 32'hCAFE_F00D);
    chk("R1 data array load port", wval[4], 32'h1234_5678);
    chk("R7 single store", 32'(st_cnt), 32'd1);
  endtask

  task automatic t_branch();
    clr_prog();
    prog[0]  = ei(6'h08, 0, 1, 1);
    prog[1]  = ei(6'h04, 0, 0, 4);     // taken, skip prog[2]
    prog[2]  = ei(6'h08, 0, 2, 1);
    prog[3]  = ei(6'h08, 0, 3, 2);
    prog[4]  = ei(6'h05, 0, 0, 4);     // not taken
    prog[5]  = ei(6'h08, 0, 4, 3);
    prog[6]  = ei(6'h05, 1, 0, 4);     // taken, skip prog[7]
    prog[7]  = ei(6'h08, 0, 5, 9);
    prog[8]  = ei(6'h04, 1, 0, 8);     // not taken
    prog[9]  = ej(4);                  // skip prog[10]
    prog[10] = ei(6'h08, 0, 6, 7);
    prog[11] = ei(6'h08, 0, 7, 8);
    prog[12] = ei(6'h08, 0, 8, 3);
    prog[13] = ei(6'h08, 8, 8, -1);
    prog[14] = ei(6'h05, 8, 0, -8);    // back to prog[13]
    boot();
    run(140);
    chk("R8 taken zero-branch skips", 32'(wcnt[2]), 32'd0);
    chk("R8 fall-through after skip", wval[3], 32'd2);
    chk("R8 not-taken nonzero-branch", wval[4], 32'd3);
    chk("R8 taken nonzero-branch skips", 32'(wcnt[5]), 32'd0);
    chk("R9 jump skips", 32'(wcnt[6]), 32'd0);
    chk("R9 jump target", wval[7], 32'd8);
    chk("R8 backward loop count", 32'(wcnt[8]), 32'd4);
    chk("R8 loop final value", wval[8], 32'd0);
    chk("R3 loop parks on self-jump", pc_o, 32'd60);
  endtask

  task automatic t_zero();
    clr_prog();
    prog[0] = ei(6'h08, 0, 0, 9);
    prog[1] = er(0, 0, 1, 11'h020);
    prog[2] = ei(6'h2B, 0, 0, 8);
    boot();
    run(30);
    chk("R10 no write to r0", 32'(wcnt[0]), 32'd0);
    chk("R10 r0 reads zero", wval[1], 32'd0);
    chk("R10 r0 stored as zero", st_data_l, 32'd0);
  endtask

  task automatic t_illegal();
    clr_prog();
    prog[0] = {6'h3E, 5'd0, 5'd3, 16'h0005};
    prog[1] = er(0, 0, 1, 11'h7FF);
    prog[2] = ei(6'h08, 0, 2, 5);
    boot();
    run(30);
    chk("R11 illegal pulses", 32'(ill_cnt), 32'd2);
    chk("R11 pulse width", 32'(ill_max), 32'd1);
    chk("R11 no write bad opcode", 32'(wcnt[3]), 32'd0);
    chk("R11 no write bad func", 32'(wcnt[1]), 32'd0);
    chk("R11 no store", 32'(st_cnt), 32'd0);
    chk("R11 execution continues", wval[2], 32'd5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=done", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_timing();
    t_ralu();
    t_ialu();
    t_mem();
    t_branch();
    t_zero();
    t_illegal();
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule